// File: doc/BRIEF.md
# Trap-Control Register Access Guard

This block decides what happens when software tries to read or write the hypervisor's fine-grained debug trap-control register. For every access request it looks at the requesting privilege level, the nested-virtualization controls, whether the hypervisor is enabled, whether a top (most privileged) level exists and has enabled fine-grained traps, and the halted-debug state. It then reports exactly one outcome: undefined, trap to the hypervisor, trap to the top level, redirect to a memory slot, or direct access.

The decision is computed combinationally and registered once, so the result appears on the cycle after the request. Alongside the outcome the block drives the exception-class code for traps and the memory offset for redirects. A build-time parameter picks whether the halted-with-secure-debug-disabled condition is tested before or only inside the top-level trap check. The register storage itself lives elsewhere.

Top module: `tg_access_guard`

## Requirements
- R1: Level encoding is 0 user, 1 kernel, 2 hypervisor, 3 top. Any request from level 0 yields the undefined outcome.
- R2: A kernel-level request with the hypervisor enabled and both nest bits set ({NV2,NV} = 11) yields the redirect outcome with offset 0x1D0.
- R3: A kernel-level request with the hypervisor enabled, NV = 1 and NV2 = 0 traps to the hypervisor with exception class 0x18.
- R4: Any other kernel-level request (hypervisor disabled, or NV = 0) is undefined.
- R5: A hypervisor-level request, with the top level present and its trap enable at 0, traps to the top level with class 0x18, except that it is undefined when the core is halted and secure debug is disabled.
- R6: With HALT_FIRST = 1, a hypervisor-level request while halted with secure debug disabled is undefined whatever the top-level state.
- R7: A hypervisor-level request not covered by R5 or R6, and every top-level request, yields direct access.
- R8: Writes and reads receive identical outcomes; the write flag is only echoed on `res_write`.
- R9: The outcome is one-hot (bit 0 undefined, 1 trap-hypervisor, 2 trap-top, 3 redirect, 4 direct), appears one cycle after the request with `res_valid`, and exactly one bit is set for every valid result.
- R10: Exception class is 0 unless a trap outcome is reported; the offset is 0 unless a redirect is reported; with no valid result and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_level | input | 2 | Requesting privilege level |
| nest_ctl | input | 2 | {NV2, NV} nested-virtualization bits |
| hyp_on | input | 1 | Hypervisor level enabled |
| top_exists | input | 1 | Top level implemented |
| top_fgt_on | input | 1 | Top-level fine-grained trap enable |
| dbg_halted | input | 1 | Core in halted debug state |
| sec_dbg_off | input | 1 | Secure debug disabled |
| res_valid | output | 1 | Result valid |
| res_write | output | 1 | Echo of the request's write flag |
| res_outcome | output | 5 | One-hot outcome |
| res_class | output | 6 | Exception class for traps |
| res_offset | output | 12 | Redirect memory offset |

## Verification
A wrong priority or a mis-decoded nest pair shows up as a different one-hot bit on the very next cycle after the offending request, since nothing is held across requests. Every combination of level, nest bits and the five status flags is applied for both reads and writes on two instances, one per HALT_FIRST setting, and each registered result is compared against a behavioural model one cycle later. A stale class or offset field would show as a nonzero value next to a non-trap or non-redirect outcome.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int OC_W    = 5;
    localparam int EC_W    = 6;
    localparam int OFF_W   = 12;
    localparam int LVL_W   = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_USER   = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYP    = 2'd2,
        LVL_TOP    = 2'd3
    } level_e;

    localparam int OC_UNDEF    = 0;
    localparam int OC_TRAP_HYP = 1;
    localparam int OC_TRAP_TOP = 2;
    localparam int OC_REDIRECT = 3;
    localparam int OC_DIRECT   = 4;

    localparam logic [EC_W-1:0] EC_SYSREG = 6'h18;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [OC_W-1:0]  oc;
        logic [EC_W-1:0]  ec;
        logic [OFF_W-1:0] off;
    } result_t;
endpackage

// File: rtl/tg_lower_eval.sv
// Outcome for requests from the user and kernel levels.
module tg_lower_eval
    import tg_pkg::*;
(
    input  logic             is_kernel,
    input  logic [1:0]       nest,
    input  logic             hyp_on,
    output logic [OC_W-1:0]  oc
);
    logic nv, nv2;
    assign nv  = nest[0];
    assign nv2 = nest[1];

    always_comb begin
        oc = '0;
        if (is_kernel && hyp_on && nv && nv2)
            oc[OC_REDIRECT] = 1'b1;
        else if (is_kernel && hyp_on && nv)
            oc[OC_TRAP_HYP] = 1'b1;
        else
            oc[OC_UNDEF] = 1'b1;
    end
endmodule

// File: rtl/tg_upper_eval.sv
// Outcome for requests from the hypervisor and top levels.
module tg_upper_eval
    import tg_pkg::*;
#(
    parameter bit HALT_FIRST = 1'b0
) (
    input  logic             is_hyp,
    input  logic             top_exists,
    input  logic             top_fgt_on,
    input  logic             dbg_halted,
    input  logic             sec_dbg_off,
    output logic [OC_W-1:0]  oc
);
    logic locked;
    logic top_trap;
    logic early_undef;

    assign locked   = dbg_halted && sec_dbg_off;
    assign top_trap = is_hyp && top_exists && !top_fgt_on;

    generate
        if (HALT_FIRST) begin : g_halt_first
            assign early_undef = is_hyp && locked;
        end else begin : g_halt_inner
            assign early_undef = 1'b0;
        end
    endgenerate

    always_comb begin
        oc = '0;
        if (early_undef)
            oc[OC_UNDEF] = 1'b1;
        else if (top_trap && locked)
            oc[OC_UNDEF] = 1'b1;
        else if (top_trap)
            oc[OC_TRAP_TOP] = 1'b1;
        else
            oc[OC_DIRECT] = 1'b1;
    end
endmodule

// File: rtl/tg_encode.sv
// Side fields that accompany the outcome.
module tg_encode
    import tg_pkg::*;
#(
    parameter logic [OFF_W-1:0] SLOT = 12'h1D0
) (
    input  logic [OC_W-1:0]  oc,
    output logic [EC_W-1:0]  ec,
    output logic [OFF_W-1:0] off
);
    always_comb begin
        ec  = (oc[OC_TRAP_HYP] || oc[OC_TRAP_TOP]) ? EC_SYSREG : '0;
        off = oc[OC_REDIRECT] ? SLOT : '0;
    end
endmodule

// File: rtl/tg_access_guard.sv
module tg_access_guard
    import tg_pkg::*;
#(
    parameter bit               HALT_FIRST = 1'b0,
    parameter logic [OFF_W-1:0] SLOT       = 12'h1D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [1:0]        nest_ctl,
    input  logic              hyp_on,
    input  logic              top_exists,
    input  logic              top_fgt_on,
    input  logic              dbg_halted,
    input  logic              sec_dbg_off,
    output logic              res_valid,
    output logic              res_write,
    output logic [OC_W-1:0]   res_outcome,
    output logic [EC_W-1:0]   res_class,
    output logic [OFF_W-1:0]  res_offset
);
    logic [OC_W-1:0]  lo_oc, hi_oc, sel_oc;
    logic [EC_W-1:0]  enc_ec;
    logic [OFF_W-1:0] enc_off;
    logic             is_upper;
    result_t          res_d, res_q;

    assign is_upper = req_level[1];

    tg_lower_eval u_lower (
        .is_kernel (req_level == LVL_KERNEL),
        .nest      (nest_ctl),
        .hyp_on    (hyp_on),
        .oc        (lo_oc)
    );

    tg_upper_eval #(.HALT_FIRST(HALT_FIRST)) u_upper (
        .is_hyp      (req_level == LVL_HYP),
        .top_exists  (top_exists),
        .top_fgt_on  (top_fgt_on),
        .dbg_halted  (dbg_halted),
        .sec_dbg_off (sec_dbg_off),
        .oc          (hi_oc)
    );

    assign sel_oc = is_upper ? hi_oc : lo_oc;

    tg_encode #(.SLOT(SLOT)) u_enc (
        .oc  (sel_oc),
        .ec  (enc_ec),
        .off (enc_off)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.vld = 1'b1;
            res_d.wr  = req_write;
            res_d.oc  = sel_oc;
            res_d.ec  = enc_ec;
            res_d.off = enc_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid   = res_q.vld;
    assign res_write   = res_q.wr;
    assign res_outcome = res_q.oc;
    assign res_class   = res_q.ec;
    assign res_offset  = res_q.off;

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones(res_outcome) == 1);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_outcome == '0 && res_class == '0 && res_offset == '0));

    assert_trap_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_outcome[OC_TRAP_HYP] || res_outcome[OC_TRAP_TOP]) |-> res_class == EC_SYSREG);

    assert_user_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == LVL_USER) |=> res_outcome[OC_UNDEF]);

    assert_top_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == LVL_TOP) |=> res_outcome[OC_DIRECT]);

    assert_redirect_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_outcome[OC_REDIRECT] |-> res_offset == SLOT);
endmodule

// File: tb/sim_tg_access_guard.sv
module sim_tg_access_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_level = '0, nest_ctl = '0;
    logic        hyp_on = 0, top_exists = 0, top_fgt_on = 0, dbg_halted = 0, sec_dbg_off = 0;
    logic        v0, w0, v1, w1;
    logic [4:0]  o0, o1;
    logic [5:0]  c0, c1;
    logic [11:0] f0, f1;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    tg_access_guard #(.HALT_FIRST(1'b0)) u0 (
        .clk, .rst_n, .req_valid, .req_write, .req_level, .nest_ctl, .hyp_on,
        .top_exists, .top_fgt_on, .dbg_halted, .sec_dbg_off,
        .res_valid(v0), .res_write(w0), .res_outcome(o0), .res_class(c0), .res_offset(f0));

    tg_access_guard #(.HALT_FIRST(1'b1)) u1 (
        .clk, .rst_n, .req_valid, .req_write, .req_level, .nest_ctl, .hyp_on,
        .top_exists, .top_fgt_on, .dbg_halted, .sec_dbg_off,
        .res_valid(v1), .res_write(w1), .res_outcome(o1), .res_class(c1), .res_offset(f1));

    // Behavioural model: returns the expected outcome index and the governing tag.
    function automatic int model(input int lvl, input int nest, input bit hy, input bit tp,
                                 input bit fe, input bit hl, input bit sd, input bit hf,
                                 output string tag);
        if (lvl == 0) begin tag = "R1"; return 0; end
        if (lvl == 1) begin
            if (hy && nest == 3) begin tag = "R2"; return 3; end
            if (hy && nest == 1) begin tag = "R3"; return 1; end
            tag = "R4"; return 0;
        end
        if (lvl == 3) begin tag = "R7"; return 4; end
        if (hf && hl && sd) begin tag = "R6"; return 0; end
        if (tp && !fe) begin
            tag = "R5";
            return (hl && sd) ? 0 : 2;
        end
        tag = "R7"; return 4;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_inst(input string tag, input int idx, input bit wr,
                              input logic v, input logic w, input logic [4:0] o,
                              input logic [5:0] c, input logic [11:0] f);
        int ec_exp  = (idx == 1 || idx == 2) ? 'h18 : 0;
        int off_exp = (idx == 3) ? 'h1D0 : 0;
        string t2   = wr ? {tag, "/R8"} : tag;
        check("R9", "valid", v, 1);
        check(t2, "outcome", o, 1 << idx);
        check("R10", "class", c, ec_exp);
        check("R10", "offset", f, off_exp);
        check("R8", "write echo", w, wr);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R10)
        check("R10", "reset valid", v0, 0);
        check("R10", "reset outcome", o0, 0);
        check("R10", "reset class", c1, 0);
        check("R10", "reset offset", f1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2048; i++) begin
            string tg0, tg1;
            int    e0, e1;
            req_valid   = 1'b1;
            req_write   = i[0];
            req_level   = i[2:1];
            nest_ctl    = i[4:3];
            hyp_on      = i[5];
            top_exists  = i[6];
            top_fgt_on  = i[7];
            dbg_halted  = i[8];
            sec_dbg_off = i[9];
            e0 = model(int'(i[2:1]), int'(i[4:3]), i[5], i[6], i[7], i[8], i[9], 1'b0, tg0);
            e1 = model(int'(i[2:1]), int'(i[4:3]), i[5], i[6], i[7], i[8], i[9], 1'b1, tg1);
            @(posedge clk); #1;
            check_inst(tg0, e0, i[0], v0, w0, o0, c0, f0);
            check_inst(tg1, e1, i[0], v1, w1, o1, c1, f1);
            if (i[10]) begin
                // idle cycle between requests: all outputs drop (R10)
                req_valid = 1'b0;
                @(posedge clk); #1;
                check("R10", "idle valid", v0, 0);
                check("R10", "idle outcome", o1, 0);
                check("R10", "idle class", c0, 0);
            end
            @(negedge clk);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule